// File: doc/BRIEF.md
# Pulse-Stream Bit Clock Recovery Loop

This block recovers a bit-rate timing strobe from an asynchronous return-to-zero pulse train, using nothing but a fast system clock. The raw pulse input is brought into the clock domain through two flip-flops, and separate detectors then mark its leading and trailing edges. A numerically controlled phase accumulator runs at a rate set by a frequency word. The accumulator's carry-out is the recovered clock: a single-cycle strobe that falls at the centre of each bit.

Each time a leading edge arrives, the upper bits of the accumulator phase are latched into one register. Each trailing edge latches them into a second register. Both latched values are read as signed numbers and added. If the clock is centred on the pulse, the two values cancel. Only the sign of the sum is used, and it moves the frequency word up or down by one count. The word is clamped between two parameter bounds, so the loop cannot wander outside the expected data-rate window.

Top module: `pulse_clock_recovery`

## Requirements
- R1: `pulseIn` passes through two synchroniser flip-flops and then an edge-history flip-flop. A leading edge driven just after clock edge k is recognised in the cycle after edge k+2, and it is captured at edge k+3. A trailing edge is handled with the same timing.
- R2: The phase sample is the top CAP_W bits of the accumulator, read as two's complement. The leading-edge strobe loads it into the leading-edge register, and the trailing-edge strobe loads it into the trailing-edge register.
- R3: When the sign-extended sum of the two captured samples is negative, the frequency word increases by exactly one.
- R4: When that sum is zero or positive, the frequency word decreases by exactly one. An exact tie therefore slows the clock.
- R5: The frequency word never rises above FW_MAX. An increment request at FW_MAX leaves it at FW_MAX.
- R6: The frequency word never falls below FW_MIN. A decrement request at FW_MIN leaves it at FW_MIN.
- R7: The frequency word changes at most once per pulse, and only at the clock edge one cycle after the trailing-edge capture. For a trailing edge driven just after edge k, that is edge k+4.
- R8: The phase accumulator adds the frequency word on every clock. `bitStrobe` is the registered carry-out and is one cycle wide. With frequency word F and accumulator width ACC_W, and starting from phase 0, the first strobe follows edge 2^ACC_W/F after reset release, and strobes then repeat every 2^ACC_W/F cycles.
- R9: A synchronous active-high `rst` clears the synchroniser, the edge history, both capture registers, the accumulator and `bitStrobe`. It also loads the frequency word with (FW_MIN+FW_MAX)/2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | High-speed system clock; every register uses it |
| rst | input | 1 | Synchronous active-high reset |
| pulseIn | input | 1 | Asynchronous return-to-zero pulse stream |
| bitStrobe | output | 1 | One-cycle strobe at each recovered bit centre |
| freqWord | output | ACC_W | Current phase increment (frequency word) |

## Verification
Two events can coincide in one cycle: the accumulator wrap that produces `bitStrobe`, and the capture of a pulse edge. In the early-pulse scenario, the trailing edge is timed so that it is latched on the same edge where the phase wraps through zero. The captured value must then be zero and count as non-negative, so the sum equals the negative leading-edge sample and the word rises by one. A second case places both samples symmetrically around the wrap so that their sum is exactly zero; this checks that a tie decrements the word.

// File: rtl/prc_pkg.sv
package prc_pkg;

  // Strobes from the edge-control logic to the datapath
  typedef struct packed {
    logic riseStb;   // leading pulse edge seen this cycle
    logic fallStb;   // trailing pulse edge seen this cycle
    logic updStb;    // step the frequency word this cycle
  } ctlStrobes_t;

endpackage

// File: rtl/prc_control.sv
module prc_control
  import prc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        pulseIn,
  output ctlStrobes_t ctl
);

  logic syncA;
  logic syncB;
  logic prevB;
  logic updReg;
  logic riseNow;
  logic fallNow;

  assign riseNow = syncB & ~prevB;
  assign fallNow = ~syncB & prevB;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncA  <= 1'b0;
      syncB  <= 1'b0;
      prevB  <= 1'b0;
      updReg <= 1'b0;
    end else begin
      syncA  <= pulseIn;
      syncB  <= syncA;
      prevB  <= syncB;
      // step follows the trailing-edge capture by one cycle
      updReg <= fallNow;
    end
  end

  always_comb begin
    ctl.riseStb = riseNow;
    ctl.fallStb = fallNow;
    ctl.updStb  = updReg;
  end

endmodule

// File: rtl/prc_datapath.sv
module prc_datapath
  import prc_pkg::*;
#(
  parameter int unsigned ACC_W  = 24,
  parameter int unsigned CAP_W  = 8,
  parameter int unsigned FW_MIN = 245760,
  parameter int unsigned FW_MAX = 278528
) (
  input  logic             clk,
  input  logic             rst,
  input  ctlStrobes_t      ctl,
  output logic             bitStrobe,
  output logic [ACC_W-1:0] freqWord
);

  localparam logic [ACC_W-1:0] FW_LO  = ACC_W'(FW_MIN);
  localparam logic [ACC_W-1:0] FW_HI  = ACC_W'(FW_MAX);
  localparam logic [ACC_W-1:0] FW_MID = ACC_W'((FW_MIN + FW_MAX) / 2);
  localparam logic [ACC_W-1:0] ONE    = ACC_W'(1);

  logic [ACC_W-1:0]  phaseAcc;
  logic [ACC_W:0]    accSum;
  logic [CAP_W-1:0]  phaseTop;
  logic [CAP_W-1:0]  riseCap;
  logic [CAP_W-1:0]  fallCap;
  logic signed [CAP_W:0] phaseSum;
  logic              lagging;
  logic [ACC_W-1:0]  fwNext;

  // phase accumulator with carry as recovered clock
  assign accSum   = {1'b0, phaseAcc} + {1'b0, freqWord};
  assign phaseTop = phaseAcc[ACC_W-1 -: CAP_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseAcc  <= '0;
      bitStrobe <= 1'b0;
    end else begin
      phaseAcc  <= accSum[ACC_W-1:0];
      bitStrobe <= accSum[ACC_W];
    end
  end

  // phase samples at the two pulse edges
  always_ff @(posedge clk) begin
    if (rst) begin
      riseCap <= '0;
      fallCap <= '0;
    end else begin
      if (ctl.riseStb) riseCap <= phaseTop;
      if (ctl.fallStb) fallCap <= phaseTop;
    end
  end

  // signed comparison: only the sign of the sum is used
  assign phaseSum = $signed({riseCap[CAP_W-1], riseCap})
                  + $signed({fallCap[CAP_W-1], fallCap});
  assign lagging  = phaseSum[CAP_W];

  // bounded up/down frequency word
  always_comb begin
    fwNext = freqWord;
    if (ctl.updStb) begin
      if (lagging) begin
        fwNext = (freqWord >= FW_HI) ? FW_HI : freqWord + ONE;
      end else begin
        fwNext = (freqWord <= FW_LO) ? FW_LO : freqWord - ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) freqWord <= FW_MID;
    else     freqWord <= fwNext;
  end

endmodule

// File: rtl/pulse_clock_recovery.sv
module pulse_clock_recovery
  import prc_pkg::*;
#(
  parameter int unsigned ACC_W  = 24,
  parameter int unsigned CAP_W  = 8,
  parameter int unsigned FW_MIN = 245760,
  parameter int unsigned FW_MAX = 278528
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pulseIn,
  output logic             bitStrobe,
  output logic [ACC_W-1:0] freqWord
);

  ctlStrobes_t ctlBus;

  prc_control u_control (
    .clk     (clk),
    .rst     (rst),
    .pulseIn (pulseIn),
    .ctl     (ctlBus)
  );

  prc_datapath #(
    .ACC_W  (ACC_W),
    .CAP_W  (CAP_W),
    .FW_MIN (FW_MIN),
    .FW_MAX (FW_MAX)
  ) u_datapath (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctlBus),
    .bitStrobe (bitStrobe),
    .freqWord  (freqWord)
  );

endmodule

// File: rtl/prc_checker.sv
module prc_checker
  import prc_pkg::*;
#(
  parameter int unsigned ACC_W  = 24,
  parameter int unsigned CAP_W  = 8,
  parameter int unsigned FW_MIN = 245760,
  parameter int unsigned FW_MAX = 278528
) (
  input logic             clk,
  input logic             rst,
  input logic             pulseIn,
  input logic             bitStrobe,
  input logic [ACC_W-1:0] freqWord,
  input ctlStrobes_t      ctlBus
);

  localparam logic [ACC_W-1:0] FW_LO  = ACC_W'(FW_MIN);
  localparam logic [ACC_W-1:0] FW_HI  = ACC_W'(FW_MAX);
  localparam logic [ACC_W-1:0] FW_MID = ACC_W'((FW_MIN + FW_MAX) / 2);

  logic [1:0] sinceRst = '0;

  always_ff @(posedge clk) begin
    if (rst)                sinceRst <= '0;
    else if (sinceRst != 3) sinceRst <= sinceRst + 2'd1;
  end

  AST_RISE_SYNC_DELAY: assert property (@(posedge clk) disable iff (rst)
    (sinceRst == 3) && ctlBus.riseStb |-> $past(pulseIn, 2) && !$past(pulseIn, 3)); // R1

  AST_FALL_SYNC_DELAY: assert property (@(posedge clk) disable iff (rst)
    (sinceRst == 3) && ctlBus.fallStb |-> !$past(pulseIn, 2) && $past(pulseIn, 3)); // R1

  AST_FW_BELOW_MAX: assert property (@(posedge clk) disable iff (rst)
    freqWord <= FW_HI); // R5

  AST_FW_ABOVE_MIN: assert property (@(posedge clk) disable iff (rst)
    freqWord >= FW_LO); // R6

  AST_FW_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (sinceRst != 0) && !$stable(freqWord) |->
      (freqWord == $past(freqWord) + 1'b1) || (freqWord == $past(freqWord) - 1'b1)); // R3

  AST_FW_AFTER_UPDATE: assert property (@(posedge clk) disable iff (rst)
    (sinceRst != 0) && !$stable(freqWord) |-> $past(ctlBus.updStb)); // R7

  AST_UPDATE_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
    (sinceRst != 0) && ctlBus.updStb |-> $past(ctlBus.fallStb)); // R7

  // holds while the frequency word stays below half the accumulator range
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    bitStrobe |=> !bitStrobe); // R8

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (freqWord == FW_MID) && !bitStrobe); // R9

endmodule

bind pulse_clock_recovery prc_checker #(
  .ACC_W  (ACC_W),
  .CAP_W  (CAP_W),
  .FW_MIN (FW_MIN),
  .FW_MAX (FW_MAX)
) u_prc_checker (
  .clk       (clk),
  .rst       (rst),
  .pulseIn   (pulseIn),
  .bitStrobe (bitStrobe),
  .freqWord  (freqWord),
  .ctlBus    (ctlBus)
);

// File: tb/test_pulse_clock_recovery.sv
`timescale 1ns/1ps
module test_pulse_clock_recovery;

  localparam int unsigned ACC_W  = 16;
  localparam int unsigned CAP_W  = 8;
  localparam int unsigned FW_MIN = 1021;
  localparam int unsigned FW_MAX = 1027;
  localparam int          MIDV   = 1024;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             pulseIn = 1'b0;
  logic             bitStrobe;
  logic [ACC_W-1:0] freqWord;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  always #2 clk = ~clk;

  pulse_clock_recovery #(
    .ACC_W  (ACC_W),
    .CAP_W  (CAP_W),
    .FW_MIN (FW_MIN),
    .FW_MAX (FW_MAX)
  ) i_pulse_clock_recovery (
    .clk       (clk),
    .rst       (rst),
    .pulseIn   (pulseIn),
    .bitStrobe (bitStrobe),
    .freqWord  (freqWord)
  );

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic doReset();
    rst     = 1'b1;
    pulseIn = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // returns the number of negedges waited; ends on a negedge with bitStrobe high
  task automatic waitStrobe(output int waited);
    waited = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (!bitStrobe && waited < 1000);
  endtask

  // pulse placed riseM/fallM edges after a strobe; checks R7 timing and the new word
  task automatic sendPulse(input int riseM, input int fallM, input int expFw, input string req);
    int w;
    int oldFw;
    waitStrobe(w);
    repeat (riseM) @(negedge clk);
    pulseIn = 1'b1;
    repeat (fallM - riseM) @(negedge clk);
    oldFw   = int'(freqWord);
    pulseIn = 1'b0;
    repeat (3) @(negedge clk);
    check(int'(freqWord) == oldFw, "R7 word held until update edge", int'(freqWord), oldFw);
    @(negedge clk);
    check(int'(freqWord) == expFw, req, int'(freqWord), expFw);
  endtask

  task automatic testReset();
    doReset();
    check(int'(freqWord) == MIDV, "R9 word at midpoint", int'(freqWord), MIDV);
    check(bitStrobe == 1'b0, "R9 strobe low after reset", int'(bitStrobe), 0);
  endtask

  task automatic testPeriod();
    int w;
    doReset();
    waitStrobe(w);
    check(w == 64, "R8 first strobe after 64 edges", w, 64);
    @(negedge clk);
    check(bitStrobe == 1'b0, "R8 strobe one cycle wide", int'(bitStrobe), 0);
    waitStrobe(w);
    check(w == 63, "R8 strobe period 64", w + 1, 64);
  endtask

  task automatic testTie();
    doReset();
    // rise sample -20, fall sample +20: zero sum slows the clock
    sendPulse(57, 67, MIDV - 1, "R4 tie decrements");
  endtask

  task automatic testEarly();
    doReset();
    // rise sample -20, fall captured on the wrap edge (0): negative sum
    sendPulse(57, 62, MIDV + 1, "R3 early pulse increments");
  endtask

  task automatic testLate();
    doReset();
    // rise sample 0, fall sample +20: positive sum (R2 sample routing)
    sendPulse(62, 67, MIDV - 1, "R2 late pulse decrements");
  endtask

  task automatic testSatMax();
    doReset();
    for (int i = 1; i <= 5; i++) begin
      int exp = (MIDV + i > int'(FW_MAX)) ? int'(FW_MAX) : MIDV + i;
      sendPulse(57, 62, exp, "R5 clamp at maximum");
    end
  endtask

  task automatic testSatMin();
    doReset();
    for (int i = 1; i <= 5; i++) begin
      int exp = (MIDV - i < int'(FW_MIN)) ? int'(FW_MIN) : MIDV - i;
      sendPulse(62, 67, exp, "R6 clamp at minimum");
    end
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(int'(freqWord) == MIDV, "R9 reset restores midpoint", int'(freqWord), MIDV);
    check(bitStrobe == 1'b0, "R9 reset clears strobe", int'(bitStrobe), 0);
  endtask

  task automatic testSyncDelay();
    int oldFw;
    doReset();
    // a pulse dropped within the synchroniser window still reaches the word on edge k+4
    repeat (10) @(negedge clk);
    pulseIn = 1'b1;
    repeat (6) @(negedge clk);
    oldFw   = int'(freqWord);
    pulseIn = 1'b0;
    repeat (2) @(negedge clk);
    check(int'(freqWord) == oldFw, "R1 no change two edges after fall", int'(freqWord), oldFw);
    repeat (2) @(negedge clk);
    check(int'(freqWord) != oldFw, "R1 word moves at edge k+4", int'(freqWord), oldFw + 1);
  endtask

  initial begin
    testReset();
    testPeriod();
    testTie();
    testEarly();
    testLate();
    testSatMax();
    testSatMin();
    testSyncDelay();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule